// File: doc/BRIEF.md
# Word-Addressed Flash Controller with Coefficient RAM Shadow

This block models the device-side register interface of a small 16-bit flash array and the coefficient RAM that shadows it. Host logic writes three registers: a command register, an address register and a write-data register. It then polls bit 0 of the command register until the operation ends. A fourth register returns the word fetched by the last read command.

Five operations are supported: whole-array erase, single-page erase, word program, word read and a bulk copy of the flash into the coefficient RAM. Each operation keeps the busy bit set for its own parameterised number of clock cycles. Its effect on storage takes place on the edge where busy clears. The filter datapath reads the coefficient RAM through a separate combinational port. Each 32-bit RAM word is built from two adjacent flash words.

Top module: `flash_shadow_ctl`

## Requirements
- R1: After reset, the command register reads 0000h, the read-data register reads 0000h, every RAM word reads 0, and every flash word reads FFFFh when it is fetched.
- R2: A valid command written while idle sets bit 0 of the command register for exactly T cycles, where T is the duration parameter of that operation (whole erase T_MASS, page erase T_PAGE, program T_PROG, read T_READ, copy T_COPY).
- R3: Command 20h stores (old word AND write-data register) at the word given by the address register, so programming can only clear bits.
- R4: Command A0h loads the addressed flash word into the read-data register (select 3) when busy clears.
- R5: Command 40h sets every word of the page given by the upper address bits (address / WPP) to FFFFh and leaves the other pages unchanged.
- R6: Command 60h sets every flash word to FFFFh.
- R7: Command C0h sets RAM word i to {flash[2i], flash[2i+1]}, with the even word in bits 31:16. The RAM does not change at any other time.
- R8: While busy, writes to any register are ignored and set bit 1 of the command register, which stays set until the next write to the command register while idle.
- R9: A command-register write while idle with a code other than 20h, 40h, 60h, A0h or C0h starts nothing, so busy stays 0. The register selects are 0 = command, 1 = address, 2 = write data, 3 = read data (read-only).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register select for both write and read |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Contents of the selected register (combinational) |
| cram_raddr_i | input | AW-1 | Coefficient RAM read address |
| cram_rdata_o | output | 32 | Coefficient RAM read data (combinational) |

## Verification
The assertions assume that every duration parameter is at least 1 and that T_MASS is the largest, so the busy counter can hold each count. They also assume that the write strobe is a clean single-cycle level. The stimulus changes inputs just after a rising edge and holds each write for exactly one edge. Writes made during busy are placed on purpose inside a long page erase, so that the ignore and error paths are exercised while the timer is still running.

// File: rtl/flashctl_pkg.sv
package flashctl_pkg;
  typedef enum logic [2:0] {
    OP_NONE, OP_MASS, OP_PAGE, OP_PROG, OP_READ, OP_COPY
  } op_e;

  localparam logic [1:0] SEL_MODE = 2'd0;
  localparam logic [1:0] SEL_ADDR = 2'd1;
  localparam logic [1:0] SEL_DIN  = 2'd2;
  localparam logic [1:0] SEL_DOUT = 2'd3;

  localparam logic [7:0] CMD_PROG = 8'h20;
  localparam logic [7:0] CMD_PAGE = 8'h40;
  localparam logic [7:0] CMD_MASS = 8'h60;
  localparam logic [7:0] CMD_READ = 8'hA0;
  localparam logic [7:0] CMD_COPY = 8'hC0;

  function automatic op_e decode_cmd(input logic [7:0] c);
    case (c)
      CMD_PROG: return OP_PROG;
      CMD_PAGE: return OP_PAGE;
      CMD_MASS: return OP_MASS;
      CMD_READ: return OP_READ;
      CMD_COPY: return OP_COPY;
      default:  return OP_NONE;
    endcase
  endfunction
endpackage

// File: rtl/flash_seq.sv
module flash_seq
  import flashctl_pkg::*;
#(
  parameter int T_MASS = 4000,
  parameter int T_PAGE = 400,
  parameter int T_PROG = 40,
  parameter int T_READ = 2,
  parameter int T_COPY = 200
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [1:0] sel_i,
  input  logic [7:0] cmd_i,
  output logic       busy_o,
  output logic       err_o,
  output logic       done_o,
  output op_e        op_o
);
  localparam int CW = $clog2(T_MASS + 1);

  logic [CW-1:0] cnt_q;
  op_e           dec;

  function automatic logic [CW-1:0] dur(input op_e o);
    case (o)
      OP_MASS: return CW'(T_MASS - 1);
      OP_PAGE: return CW'(T_PAGE - 1);
      OP_PROG: return CW'(T_PROG - 1);
      OP_READ: return CW'(T_READ - 1);
      default: return CW'(T_COPY - 1);
    endcase
  endfunction

  assign dec    = decode_cmd(cmd_i);
  assign done_o = busy_o && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      err_o  <= 1'b0;
      cnt_q  <= '0;
      op_o   <= OP_NONE;
    end else if (busy_o) begin
      if (cnt_q == '0) busy_o <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
      if (we_i) err_o <= 1'b1;
    end else if (we_i && sel_i == SEL_MODE) begin
      err_o <= 1'b0;
      if (dec != OP_NONE) begin
        busy_o <= 1'b1;
        op_o   <= dec;
        cnt_q  <= dur(dec);
      end
    end
  end

  // R2
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !done_o |=> busy_o);
  // R8
  busy_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && we_i |=> err_o);
  // R8
  busy_op_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !done_o |=> $stable(op_o));
  // R9
  bad_cmd_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && we_i && sel_i == SEL_MODE && dec == OP_NONE |=> !busy_o);
endmodule

// File: rtl/flash_array.sv
module flash_array
  import flashctl_pkg::*;
#(
  parameter int PAGES = 4,
  parameter int WPP   = 32,
  localparam int DEPTH = PAGES * WPP,
  localparam int AW    = $clog2(DEPTH),
  localparam int WB    = $clog2(WPP)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          done_i,
  input  op_e           op_i,
  input  logic [AW-1:0] addr_i,
  input  logic [15:0]   din_i,
  output logic [15:0]   dout_o,
  output logic [15:0]   mem_o [DEPTH]
);
  logic [15:0] mem_q [DEPTH];
  logic [AW-WB-1:0] page;

  assign page  = addr_i[AW-1:WB];
  assign mem_o = mem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= 16'hFFFF;
      dout_o <= '0;
    end else if (done_i) begin
      case (op_i)
        OP_MASS: for (int i = 0; i < DEPTH; i++) mem_q[i] <= 16'hFFFF;
        OP_PAGE: for (int i = 0; i < WPP; i++) mem_q[{page, WB'(i)}] <= 16'hFFFF;
        OP_PROG: mem_q[addr_i] <= mem_q[addr_i] & din_i;
        OP_READ: dout_o <= mem_q[addr_i];
        default: ;
      endcase
    end
  end

  // R3
  prog_clear_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i && op_i == OP_PROG |=>
      ((mem_q[$past(addr_i)] & ~$past(mem_q[addr_i])) == 16'h0));
  // R5
  page_erased_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i && op_i == OP_PAGE |=> mem_q[{$past(page), WB'(0)}] == 16'hFFFF);
  // R6
  mass_erased_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i && op_i == OP_MASS |=> mem_q[DEPTH-1] == 16'hFFFF);
endmodule

// File: rtl/cram_shadow.sv
module cram_shadow #(
  parameter int DEPTH = 128,
  localparam int RDEPTH = DEPTH / 2,
  localparam int RAW    = $clog2(RDEPTH)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic [15:0]    flash_i [DEPTH],
  input  logic [RAW-1:0] raddr_i,
  output logic [31:0]    rdata_o
);
  logic [31:0] mem_q [RDEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < RDEPTH; i++) mem_q[i] <= '0;
    end else if (load_i) begin
      // even flash word supplies the upper half
      for (int i = 0; i < RDEPTH; i++) mem_q[i] <= {flash_i[2*i], flash_i[2*i+1]};
    end
  end

  assign rdata_o = mem_q[raddr_i];

  // R7
  cram_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(mem_q[RDEPTH-1]));
endmodule

// File: rtl/flash_shadow_ctl.sv
module flash_shadow_ctl
  import flashctl_pkg::*;
#(
  parameter int PAGES  = 4,
  parameter int WPP    = 32,
  parameter int T_MASS = 4000,
  parameter int T_PAGE = 400,
  parameter int T_PROG = 40,
  parameter int T_READ = 2,
  parameter int T_COPY = 200,
  localparam int DEPTH = PAGES * WPP,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [1:0]    reg_sel_i,
  input  logic [15:0]   reg_wdata_i,
  output logic [15:0]   reg_rdata_o,
  input  logic [AW-2:0] cram_raddr_i,
  output logic [31:0]   cram_rdata_o
);
  logic          busy, err, done;
  op_e           op;
  logic [AW-1:0] addr_q;
  logic [15:0]   din_q, dout;
  logic [15:0]   fmem [DEPTH];

  flash_seq #(
    .T_MASS(T_MASS), .T_PAGE(T_PAGE), .T_PROG(T_PROG),
    .T_READ(T_READ), .T_COPY(T_COPY)
  ) u_seq (
    .clk_i, .rst_ni, .we_i(reg_we_i), .sel_i(reg_sel_i),
    .cmd_i(reg_wdata_i[7:0]), .busy_o(busy), .err_o(err),
    .done_o(done), .op_o(op)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      din_q  <= '0;
    end else if (reg_we_i && !busy) begin
      if (reg_sel_i == SEL_ADDR) addr_q <= reg_wdata_i[AW-1:0];
      if (reg_sel_i == SEL_DIN)  din_q  <= reg_wdata_i;
    end
  end

  flash_array #(.PAGES(PAGES), .WPP(WPP)) u_arr (
    .clk_i, .rst_ni, .done_i(done), .op_i(op), .addr_i(addr_q),
    .din_i(din_q), .dout_o(dout), .mem_o(fmem)
  );

  cram_shadow #(.DEPTH(DEPTH)) u_cram (
    .clk_i, .rst_ni, .load_i(done && op == OP_COPY), .flash_i(fmem),
    .raddr_i(cram_raddr_i), .rdata_o(cram_rdata_o)
  );

  always_comb begin
    case (reg_sel_i)
      SEL_MODE: reg_rdata_o = {14'b0, err, busy};
      SEL_ADDR: reg_rdata_o = 16'(addr_q);
      SEL_DIN:  reg_rdata_o = din_q;
      default:  reg_rdata_o = dout;
    endcase
  end

  // R8
  addr_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |=> $stable(addr_q) && $stable(din_q));
endmodule

// File: tb/flash_shadow_ctl_tb_top.sv
module flash_shadow_ctl_tb_top;
  localparam int TM = 13, TPG = 9, TPR = 5, TRD = 2, TCP = 7;

  logic        clk_i = 0, rst_ni = 0;
  logic        reg_we_i = 0;
  logic [1:0]  reg_sel_i = 0;
  logic [15:0] reg_wdata_i = 0;
  logic [15:0] reg_rdata_o;
  logic [5:0]  cram_raddr_i = 0;
  logic [31:0] cram_rdata_o;

  int checks = 0, errors = 0;
  bit finished = 0;
  bit mon_req = 0;

  typedef struct {
    bit          is_cram;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t q[$];

  always #5 clk_i = ~clk_i;

  flash_shadow_ctl #(
    .PAGES(4), .WPP(32), .T_MASS(TM), .T_PAGE(TPG), .T_PROG(TPR),
    .T_READ(TRD), .T_COPY(TCP)
  ) dut_i (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected items as results appear
  always @(negedge clk_i) begin
    if (mon_req && q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it  = q.pop_front();
      act = it.is_cram ? cram_rdata_o : {16'h0, reg_rdata_o};
      chk(act === it.exp, it.tag, act, it.exp);
    end
  end

  task automatic wr(input logic [1:0] s, input logic [15:0] d);
    @(posedge clk_i); #1;
    reg_we_i = 1; reg_sel_i = s; reg_wdata_i = d;
    @(posedge clk_i); #1;
    reg_we_i = 0;
  endtask

  task automatic wait_idle();
    reg_sel_i = 0;
    @(negedge clk_i);
    while (reg_rdata_o[0]) @(negedge clk_i);
  endtask

  task automatic measure(input int exp, input string tag);
    int n = 0;
    reg_sel_i = 0;
    @(negedge clk_i);
    while (reg_rdata_o[0]) begin n++; @(negedge clk_i); end
    chk(n == exp, tag, n, exp);
  endtask

  task automatic exp_reg(input logic [1:0] s, input logic [15:0] e, input string tag);
    q.push_back('{1'b0, {16'h0, e}, tag});
    @(posedge clk_i); #1;
    reg_sel_i = s; mon_req = 1;
    @(negedge clk_i); #1;
    mon_req = 0;
  endtask

  task automatic exp_cram(input logic [5:0] a, input logic [31:0] e, input string tag);
    q.push_back('{1'b1, e, tag});
    @(posedge clk_i); #1;
    cram_raddr_i = a; mon_req = 1;
    @(negedge clk_i); #1;
    mon_req = 0;
  endtask

  task automatic fread(input logic [6:0] a);
    wr(1, {9'h0, a});
    wr(0, 16'h00A0);
    wait_idle();
  endtask

  task automatic fprog(input logic [6:0] a, input logic [15:0] d);
    wr(1, {9'h0, a});
    wr(2, d);
    wr(0, 16'h0020);
    wait_idle();
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    chk(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1;
    // R1 reset state
    exp_reg(0, 16'h0000, "R1 mode");
    exp_reg(3, 16'h0000, "R1 dout");
    exp_cram(6'h00, 32'h0, "R1 cram0");
    exp_cram(6'h3F, 32'h0, "R1 cram63");
    // R4 read of erased word, R2 read duration
    wr(1, 16'h0005);
    wr(0, 16'h00A0);
    measure(TRD, "R2 read busy");
    exp_reg(3, 16'hFFFF, "R1 R4 erased read");
    // R3 program and AND behaviour
    wr(1, 16'h0005);
    wr(2, 16'h1234);
    wr(0, 16'h0020);
    measure(TPR, "R2 prog busy");
    fread(7'h05);
    exp_reg(3, 16'h1234, "R3 R4 prog");
    fprog(7'h05, 16'hFF0F);
    fread(7'h05);
    exp_reg(3, 16'h1204, "R3 and");
    fprog(7'h76, 16'hABCD);
    fprog(7'h77, 16'h5678);
    fprog(7'h20, 16'h1111);
    fprog(7'h40, 16'h2222);
    // R7 copy
    wr(0, 16'h00C0);
    measure(TCP, "R2 copy busy");
    exp_cram(6'h3B, 32'hABCD5678, "R7 pair");
    exp_cram(6'h02, 32'hFFFF1204, "R7 even upper");
    exp_cram(6'h10, 32'h1111FFFF, "R7 page1");
    // R5 page erase of page 1
    wr(1, 16'h0020);
    wr(0, 16'h0040);
    measure(TPG, "R2 page busy");
    fread(7'h20);
    exp_reg(3, 16'hFFFF, "R5 erased page");
    fread(7'h40);
    exp_reg(3, 16'h2222, "R5 other page");
    fread(7'h05);
    exp_reg(3, 16'h1204, "R5 page0");
    exp_cram(6'h10, 32'h1111FFFF, "R7 cram held");
    // R8 writes while busy
    wr(1, 16'h0060);
    wr(0, 16'h0040);
    wr(1, 16'h0005);
    wr(2, 16'hAAAA);
    wr(0, 16'h0060);
    wait_idle();
    exp_reg(0, 16'h0002, "R8 err set");
    exp_reg(1, 16'h0060, "R8 addr held");
    exp_reg(2, 16'h2222, "R8 din held");
    fread(7'h40);
    exp_reg(3, 16'h2222, "R8 no mass erase");
    exp_reg(0, 16'h0000, "R8 err cleared");
    // R9 unknown command
    wr(1, 16'h0060);
    wr(0, 16'h0040);
    wr(1, 16'h0005);
    wait_idle();
    wr(0, 16'h0011);
    exp_reg(0, 16'h0000, "R9 R8 unknown cmd");
    // R6 mass erase
    wr(0, 16'h0060);
    measure(TM, "R2 mass busy");
    fread(7'h40);
    exp_reg(3, 16'hFFFF, "R6 w40");
    fread(7'h76);
    exp_reg(3, 16'hFFFF, "R6 w76");
    exp_cram(6'h3B, 32'hABCD5678, "R7 held after erase");
    wr(0, 16'h00C0);
    wait_idle();
    exp_cram(6'h3B, 32'hFFFFFFFF, "R7 recopy");
    repeat (2) @(posedge clk_i);
    finish_run();
  end
endmodule